// File: doc/BRIEF.md
# Wrapping Sequence Number Window Checker

This block screens the 8-bit sequence numbers arriving on one redundant-link flow. It keeps the last accepted number (`psn`) and sorts every new frame into one of three classes. A frame is accepted when its number moves the flow forward by one or two steps. A frame is a stale copy when it repeats the held number or trails it by one or two steps. Any other number is an integrity failure. The number sequence steps upward, wraps from 255 to 1, and never passes through 0. The value 0 is kept for the first frame a transmitter sends after it restarts.

The surrounding logic raises `frm_valid` for one cycle with the frame's number on `frm_seq`. One cycle later exactly one of the three result strobes is high. On an accept, `psn` takes the new number on the same edge. A `link_reset` pulse puts the checker back into an unsynchronised state, so the next frame is accepted whatever its number.

Top module: `seqwin_check`

## Requirements
- R1: While `rst_n` is low, all three strobes are low, `psn` is 0 and the checker is unsynchronised.
- R2: In the unsynchronised state (after reset or after a `link_reset` pulse), the next frame is accepted whatever its number, `psn` loads that number, and the checker becomes synchronised.
- R3: When synchronised, a frame whose number is one or two skip-zero steps after `psn` is accepted and `psn` loads it. The successor of 255 is 1 and the successor of 0 is 1, so `psn`=254 accepts 255 and 1, and `psn`=255 accepts 1 and 2.
- R4: A frame numbered 0 is always accepted and sets `psn` to 0. After that, only 1 and 2 are accepted.
- R5: When synchronised and `psn` is not 0, a nonzero number equal to `psn` or one or two skip-zero steps before it raises `rej_dup`, and `psn` is unchanged. The predecessor of 1 is 255, so `psn`=2 treats 2, 1 and 255 as stale copies. With `psn`=0 no number is a stale copy.
- R6: When synchronised, any other number raises `rej_integ`, and `psn` is unchanged.
- R7: A result strobe is high only in the cycle after a `frm_valid` cycle, and never more than one at a time. Every frame not covered by R8 gets exactly one strobe. `psn` changes only on the edge that raises `accept`.
- R8: `link_reset` takes priority over a frame in the same cycle. That frame gets no strobe and leaves `psn` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_reset | input | 1 | One-cycle pulse; drops synchronisation |
| frm_valid | input | 1 | Frame number present this cycle |
| frm_seq | input | 8 | Sequence number of the frame |
| accept | output | 1 | Frame accepted (registered) |
| rej_dup | output | 1 | Frame rejected as a stale copy |
| rej_integ | output | 1 | Frame rejected as an integrity failure |
| psn | output | 8 | Last accepted sequence number |

## Verification
The assertions assume that `frm_valid` and `link_reset` are single-cycle controls sampled at the clock. They also assume that nothing is expected from a frame that arrives together with a `link_reset`. The bench drives every input on the falling edge and holds it for exactly one cycle, so each frame is seen once. It loads a chosen `psn` by issuing a `link_reset` and then a frame carrying that number. It then sweeps every one of the 256 incoming values against sixteen held values that include 0, 1, 2, 253, 254 and 255.

// File: rtl/seqwin_check.sv
module seqwin_check #(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_reset,
  input  logic             frm_valid,
  input  logic [SEQ_W-1:0] frm_seq,
  output logic             accept,
  output logic             rej_dup,
  output logic             rej_integ,
  output logic [SEQ_W-1:0] psn
);
  localparam logic [SEQ_W-1:0] ZERO = '0;
  localparam logic [SEQ_W-1:0] ONE  = SEQ_W'(1);
  localparam logic [SEQ_W-1:0] TOP  = '1;

  function automatic logic [SEQ_W-1:0] step_up(input logic [SEQ_W-1:0] v);
    return (v == TOP || v == ZERO) ? ONE : v + ONE;
  endfunction

  function automatic logic [SEQ_W-1:0] step_down(input logic [SEQ_W-1:0] v);
    if (v == ZERO)     return ZERO;
    else if (v == ONE) return TOP;
    else               return v - ONE;
  endfunction

  logic             synced;
  logic [SEQ_W-1:0] ahead1, ahead2, behind1, behind2;
  logic             in_window, is_stale, take;

  assign ahead1  = step_up(psn);
  assign ahead2  = step_up(ahead1);
  assign behind1 = step_down(psn);
  assign behind2 = step_down(behind1);

  assign in_window = (frm_seq == ahead1) || (frm_seq == ahead2);
  assign is_stale  = (psn != ZERO) &&
                     ((frm_seq == psn) || (frm_seq == behind1) || (frm_seq == behind2));
  assign take      = !synced || (frm_seq == ZERO) || in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced    <= 1'b0;
      psn       <= ZERO;
      accept    <= 1'b0;
      rej_dup   <= 1'b0;
      rej_integ <= 1'b0;
    end else begin
      accept    <= 1'b0;
      rej_dup   <= 1'b0;
      rej_integ <= 1'b0;
      if (link_reset) begin
        synced <= 1'b0;
      end else if (frm_valid) begin
        if (take) begin
          accept <= 1'b1;
          psn    <= frm_seq;
          synced <= 1'b1;
        end else if (is_stale) begin
          rej_dup <= 1'b1;
        end else begin
          rej_integ <= 1'b1;
        end
      end
    end
  end
endmodule

module seqwin_check_props #(
  parameter int SEQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_reset,
  input logic             frm_valid,
  input logic [SEQ_W-1:0] frm_seq,
  input logic             accept,
  input logic             rej_dup,
  input logic             rej_integ,
  input logic [SEQ_W-1:0] psn
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!accept && !rej_dup && !rej_integ && psn == '0);
    end
  end

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept, rej_dup, rej_integ}));

  assert_strobe_needs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || rej_dup || rej_integ) |-> $past(frm_valid));

  assert_frame_gets_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !link_reset) |=> (accept || rej_dup || rej_integ));

  assert_psn_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> $stable(psn));

  assert_psn_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> psn == $past(frm_seq));

  assert_zero_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !link_reset && frm_seq == '0) |=> accept);

  assert_link_reset_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset |=> !(accept || rej_dup || rej_integ));

  assert_first_after_link_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_reset ##1 (frm_valid && !link_reset)) |=> accept);
endmodule

bind seqwin_check seqwin_check_props #(.SEQ_W(SEQ_W)) props_i (.*);

// File: tb/seqwin_check_test.sv
module seqwin_check_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_reset = 1'b0;
  logic       frm_valid = 1'b0;
  logic [7:0] frm_seq = 8'd0;
  logic       accept, rej_dup, rej_integ;
  logic [7:0] psn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  seqwin_check uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // model: 1 accept, 2 stale copy, 3 integrity, 0 none
  function automatic int model(input int p, input int s, input bit sy);
    int d;
    if (!sy || s == 0) return 1;
    if (p == 0) return (s == 1 || s == 2) ? 1 : 3;
    d = ((s - 1) - (p - 1) + 255) % 255;
    if (d == 1 || d == 2) return 1;
    if (d == 0 || d == 253 || d == 254) return 2;
    return 3;
  endfunction

  task automatic check(input string req, input int exp_cls, input int exp_psn);
    int got;
    got = accept ? 1 : rej_dup ? 2 : rej_integ ? 3 : 0;
    if (accept + rej_dup + rej_integ > 1) got = 9;
    checks++;
    if (got != exp_cls || psn != exp_psn[7:0]) begin
      fails++;
      $display("FAIL %s: class=%0d psn=%0d expected class=%0d psn=%0d",
               req, got, psn, exp_cls, exp_psn);
    end
  endtask

  task automatic frame(input int s, input bit lr);
    frm_valid  = 1'b1;
    frm_seq    = s[7:0];
    link_reset = lr;
    @(negedge clk);
    frm_valid  = 1'b0;
    link_reset = 1'b0;
  endtask

  task automatic relink();
    link_reset = 1'b1;
    @(negedge clk);
    link_reset = 1'b0;
  endtask

  int held_list [16] = '{0, 1, 2, 3, 4, 17, 99, 127, 128, 200, 251, 252, 253, 254, 255, 60};

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p;
    int c;
    @(negedge clk);
    check("R1", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, 0);

    // R2: first frame after reset accepted, any value
    frame(77, 1'b0); check("R2", 1, 77);
    frame(79, 1'b0); check("R3", 1, 79);
    frame(79, 1'b0); check("R5", 2, 79);
    frame(150, 1'b0); check("R6", 3, 79);
    @(negedge clk); check("R7", 0, 79);

    // R3 wrap run through 255 -> 1
    relink(); frame(253, 1'b0); check("R2", 1, 253);
    frame(254, 1'b0); check("R3", 1, 254);
    frame(1, 1'b0);   check("R3", 1, 1);
    frame(255, 1'b0); check("R5", 2, 1);
    frame(2, 1'b0);   check("R3", 1, 2);

    // R4: zero resynchronises
    frame(0, 1'b0);   check("R4", 1, 0);
    frame(3, 1'b0);   check("R4", 3, 0);
    frame(2, 1'b0);   check("R4", 1, 2);

    // R8: link_reset drops a coincident frame; next frame is first
    frame(4, 1'b1);   check("R8", 0, 2);
    frame(180, 1'b0); check("R8", 1, 180);

    // near-exhaustive sweep: every number against sixteen held values
    foreach (held_list[i]) begin
      p = held_list[i];
      for (int s = 0; s < 256; s++) begin
        relink();
        frame(p, 1'b0);
        frame(s, 1'b0);
        c = model(p, s, 1'b1);
        if (c == 1)      check("R3", c, s);
        else if (c == 2) check("R5", c, p);
        else             check("R6", c, p);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule